// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor through two independent request banks: a normal-priority bank and a fast bank. Both banks see the same source vector. Each bank keeps its own enable mask and its own software request, and drives one request output. Software masks and unmasks sources one bit at a time. It writes ones to a set window or to a clear window, so it never has to do a read-modify-write of the mask.

A bank occupies a 32-byte window in a small word-addressed register space. The masked view, the raw view and the enable view can be read. The enable view shares its word with the set window. The clear window and the software-request word can only be written. The software request can assert only source bit 1. Source bit 0 is unused and reads 0 in every view. Each source is cleared at its own peripheral, outside this block.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset both enable masks read 0, both software requests are clear, both masked views read 0 and both request outputs are 0, whatever the sources are doing.
- R2: A read at bank offset 0x4 returns the current raw source levels, ORed with that bank's software request on bit 1, regardless of enable. Bit 0 reads 0 in every view. The fast bank sees the same source vector as the normal bank.
- R3: A read at bank offset 0x0 returns the raw view ANDed bit for bit with that bank's enable mask.
- R4: A read at bank offset 0x8 returns the enable mask. A write there sets every enable bit written as 1 and leaves the other bits unchanged. The new mask can be read after the capturing clock edge.
- R5: A write at bank offset 0xC clears every enable bit written as 1 and leaves the bits written as 0 unchanged.
- R6: A write at bank offset 0x10 stores data bit 1 as that bank's software request, which drives source bit 1 of that bank only. The other data bits have no effect.
- R7: Each request output is the OR of its bank's masked view, registered once, so it changes exactly one clock edge after the masked view changes.
- R8: Writes to offsets 0x0 and 0x4 change no state. Reads of offsets 0xC and 0x10, of unaligned addresses and of addresses outside both windows return 0.
- R9: The banks are independent. A write into one bank's window never changes the other bank's enable mask or software request.
- R10: The normal bank's window starts at byte 0x180 and the fast bank's window starts at byte 0x280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive source vector; bit 0 unused |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_req_o | output | 1 | Registered request of the normal bank |
| fiq_req_o | output | 1 | Registered request of the fast bank |

## Verification
Read data is combinational from the address, the sources and the stored state, so each read is due in the same cycle the address is presented. An enable or software-request write becomes readable after the single edge that captures it, and the request outputs lag any change in the masked view by exactly one further edge. The bench drives every input on the falling edge. It checks reads and the not-yet-updated request 1 ns later, then checks the updated request at the next falling edge. This pins down the one-edge lag in both directions.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // word index inside a 32-byte bank window (byte address bits [4:2])
   typedef enum logic [2:0] {
      OFS_MASKED = 3'd0,
      OFS_RAW    = 3'd1,
      OFS_EN_SET = 3'd2,
      OFS_EN_CLR = 3'd3,
      OFS_SOFT   = 3'd4
   } intc_ofs_e;

   localparam int WIN_LSB = 5;   // bank window = 2**WIN_LSB bytes
   localparam int NBANK   = 2;
endpackage

// File: rtl/intc_enable_reg.sv
module intc_enable_reg #(
   parameter int               NSRC       = 32,
   parameter logic [NSRC-1:0]  VALID_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] en_o
);
   logic [NSRC-1:0] en_q;

   // clear takes priority over set on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q | set_i) & ~clr_i & VALID_MASK;
   end

   assign en_o = en_q;
endmodule

// File: rtl/intc_req_out.sv
module intc_req_out #(
   parameter int NSRC      = 32,
   parameter bit REGISTERED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] pend_i,
   output logic            req_o
);
   generate
      if (REGISTERED) begin : g_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= |pend_i;
         end
         assign req_o = req_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign req_o = |pend_i;
      end
   endgenerate
endmodule

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int               NSRC       = 32,
   parameter int               DW         = 32,
   parameter int               SOFT_BIT   = 1,
   parameter bit               REQ_REG    = 1'b1,
   parameter logic [NSRC-1:0]  VALID_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            wr_i,
   input  logic [2:0]      ofs_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   rdata_o,
   output logic            req_o,
   output logic [NSRC-1:0] en_o,
   output logic [NSRC-1:0] raw_o,
   output logic [NSRC-1:0] masked_o
);
   logic            soft_q;
   logic [NSRC-1:0] soft_vec;
   logic [NSRC-1:0] set_vec;
   logic [NSRC-1:0] clr_vec;
   logic            wr_set, wr_clr, wr_soft;

   assign wr_set  = wr_i && (ofs_i == OFS_EN_SET);
   assign wr_clr  = wr_i && (ofs_i == OFS_EN_CLR);
   assign wr_soft = wr_i && (ofs_i == OFS_SOFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       soft_q <= 1'b0;
      else if (wr_soft) soft_q <= wdata_i[SOFT_BIT];
   end

   always_comb begin
      soft_vec           = '0;
      soft_vec[SOFT_BIT] = soft_q;
   end

   assign set_vec = wr_set ? wdata_i[NSRC-1:0] : '0;
   assign clr_vec = wr_clr ? wdata_i[NSRC-1:0] : '0;

   intc_enable_reg #(
      .NSRC       (NSRC),
      .VALID_MASK (VALID_MASK)
   ) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .clr_i (clr_vec),
      .en_o  (en_o)
   );

   assign raw_o    = (src_i | soft_vec) & VALID_MASK;
   assign masked_o = raw_o & en_o;

   intc_req_out #(
      .NSRC       (NSRC),
      .REGISTERED (REQ_REG)
   ) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (masked_o),
      .req_o  (req_o)
   );

   always_comb begin
      rdata_o = '0;
      unique case (ofs_i)
         OFS_MASKED: rdata_o[NSRC-1:0] = masked_o;
         OFS_RAW:    rdata_o[NSRC-1:0] = raw_o;
         OFS_EN_SET: rdata_o[NSRC-1:0] = en_o;
         default:    rdata_o = '0;   // write-only or unmapped words
      endcase
   end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
   import intc_pkg::*;
#(
   parameter int            NSRC     = 32,
   parameter int            DW       = 32,
   parameter int            AW       = 12,
   parameter int            SOFT_BIT = 1,
   parameter bit            REQ_REG  = 1'b1,
   parameter logic [AW-1:0] IRQ_BASE = 12'h180,
   parameter logic [AW-1:0] FIQ_BASE = 12'h280
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            bus_wr_i,
   input  logic [AW-1:0]   bus_addr_i,
   input  logic [DW-1:0]   bus_wdata_i,
   output logic [DW-1:0]   bus_rdata_o,
   output logic            irq_req_o,
   output logic            fiq_req_o
);
   localparam logic [NSRC-1:0] VALID_MASK = {{(NSRC-1){1'b1}}, 1'b0};

   // elaboration-time parameter checks
   if (NSRC < 2 || NSRC > DW) begin : g_bad_nsrc
      $error("dual_bank_intc: NSRC must be in 2..DW");
   end
   if (SOFT_BIT < 1 || SOFT_BIT >= NSRC) begin : g_bad_soft
      $error("dual_bank_intc: SOFT_BIT must be in 1..NSRC-1");
   end
   if (AW <= WIN_LSB) begin : g_bad_aw
      $error("dual_bank_intc: AW too small for a bank window");
   end
   if (IRQ_BASE[WIN_LSB-1:0] != '0 || FIQ_BASE[WIN_LSB-1:0] != '0) begin : g_bad_align
      $error("dual_bank_intc: bank bases must be window aligned");
   end
   if (IRQ_BASE[AW-1:WIN_LSB] == FIQ_BASE[AW-1:WIN_LSB]) begin : g_bad_overlap
      $error("dual_bank_intc: bank windows overlap");
   end

   logic                       word_ok;
   logic [2:0]                 ofs;
   logic [NBANK-1:0]           hit;
   logic [NBANK-1:0]           req;
   logic [NBANK-1:0][DW-1:0]   rd_bank;
   logic [NBANK-1:0][DW-1:0]   rd_gated;
   logic [NBANK-1:0][NSRC-1:0] en_w;
   logic [NBANK-1:0][NSRC-1:0] raw_w;
   logic [NBANK-1:0][NSRC-1:0] masked_w;

   assign word_ok = (bus_addr_i[1:0] == 2'b00);
   assign ofs     = bus_addr_i[WIN_LSB-1:2];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [AW-1:0] BASE = (b == 0) ? IRQ_BASE : FIQ_BASE;

      assign hit[b] = word_ok &&
                      (bus_addr_i[AW-1:WIN_LSB] == BASE[AW-1:WIN_LSB]);

      intc_bank #(
         .NSRC       (NSRC),
         .DW         (DW),
         .SOFT_BIT   (SOFT_BIT),
         .REQ_REG    (REQ_REG),
         .VALID_MASK (VALID_MASK)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_i    (src_i),
         .wr_i     (bus_wr_i && hit[b]),
         .ofs_i    (ofs),
         .wdata_i  (bus_wdata_i),
         .rdata_o  (rd_bank[b]),
         .req_o    (req[b]),
         .en_o     (en_w[b]),
         .raw_o    (raw_w[b]),
         .masked_o (masked_w[b])
      );

      assign rd_gated[b] = hit[b] ? rd_bank[b] : '0;
   end

   always_comb begin
      bus_rdata_o = '0;
      for (int b = 0; b < NBANK; b++) bus_rdata_o |= rd_gated[b];
   end

   assign irq_req_o = req[0];
   assign fiq_req_o = req[1];
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
   parameter int            NSRC     = 32,
   parameter int            DW       = 32,
   parameter int            AW       = 12,
   parameter bit            REQ_REG  = 1'b1,
   parameter logic [AW-1:0] IRQ_BASE = 12'h180,
   parameter logic [AW-1:0] FIQ_BASE = 12'h280
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr_i,
   input logic [AW-1:0]         bus_addr_i,
   input logic [DW-1:0]         bus_wdata_i,
   input logic [DW-1:0]         bus_rdata_o,
   input logic [1:0]            req,
   input logic [1:0][NSRC-1:0]  en_w,
   input logic [1:0][NSRC-1:0]  raw_w,
   input logic [1:0][NSRC-1:0]  masked_w
);
   localparam logic [NSRC-1:0] VMASK = {{(NSRC-1){1'b1}}, 1'b0};

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata_o[0] == 1'b0);                                         // R2

   for (genvar b = 0; b < 2; b++) begin : g_b
      localparam logic [AW-1:0] BASE = (b == 0) ? IRQ_BASE : FIQ_BASE;

      AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
         !past_ok |-> (req[b] == 1'b0 && en_w[b] == '0));              // R1

      AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr_i == BASE) |-> (bus_rdata_o[NSRC-1:0] == (raw_w[b] & en_w[b]))); // R3

      AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_i && bus_addr_i == BASE + AW'(8)) |=>
         ((en_w[b] & $past(bus_wdata_i[NSRC-1:0]) & VMASK) ==
          ($past(bus_wdata_i[NSRC-1:0]) & VMASK)));                    // R4

      AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_i && bus_addr_i == BASE + AW'(12)) |=>
         ((en_w[b] & $past(bus_wdata_i[NSRC-1:0])) == '0));            // R5

      AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_i && (bus_addr_i == BASE || bus_addr_i == BASE + AW'(4))) |=>
         $stable(en_w[b]));                                            // R8

      if (REQ_REG) begin : g_lag
         AST_REQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (req[b] == $past(|masked_w[b])));              // R7
      end
   end
endmodule

bind dual_bank_intc dual_bank_intc_chk #(
   .NSRC     (NSRC),
   .DW       (DW),
   .AW       (AW),
   .REQ_REG  (REQ_REG),
   .IRQ_BASE (IRQ_BASE),
   .FIQ_BASE (FIQ_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .req         ({fiq_req_o, irq_req_o}),
   .en_w        (en_w),
   .raw_w       (raw_w),
   .masked_w    (masked_w)
);

// File: tb/dual_bank_intc_tb_top.sv
module dual_bank_intc_tb_top;
   localparam logic [31:0] VMASK = 32'hFFFF_FFFE;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] src;
   logic        bus_wr;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq_req, fiq_req;

   int vectors = 0;
   int fails   = 0;

   logic [31:0] en_m [2];
   logic        soft_m [2];
   logic        prev_m [2];

   always #10 clk = ~clk;   // 50 MHz

   dual_bank_intc dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_req_o   (irq_req),
      .fiq_req_o   (fiq_req)
   );

   function automatic logic [11:0] base(input int b);
      return (b == 0) ? 12'h180 : 12'h280;   // R10
   endfunction

   function automatic logic [31:0] raw_m(input int b);
      return (src | (soft_m[b] ? 32'h2 : 32'h0)) & VMASK;
   endfunction

   function automatic logic req_m(input int b);
      return |(raw_m(b) & en_m[b]);
   endfunction

   function automatic logic req_act(input int b);
      return (b == 0) ? irq_req : fiq_req;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one write cycle; returns at the falling edge after the capturing edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata, exp, tag);
   endtask

   // change sources at a falling edge; request holds, then follows one edge later
   task automatic step_src(input logic [31:0] s);
      for (int b = 0; b < 2; b++) prev_m[b] = req_m(b);
      src = s;
      #1;
      for (int b = 0; b < 2; b++) chk({31'b0, req_act(b)}, {31'b0, prev_m[b]}, "R7 hold");
      @(negedge clk);
      for (int b = 0; b < 2; b++) chk({31'b0, req_act(b)}, {31'b0, req_m(b)}, "R7 follow");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      en_m[0] = '0; en_m[1] = '0; soft_m[0] = 1'b0; soft_m[1] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      src = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);

      // R1: reset state
      chk({31'b0, irq_req}, 32'h0, "R1 irq req");
      chk({31'b0, fiq_req}, 32'h0, "R1 fiq req");
      for (int b = 0; b < 2; b++) begin
         rd(base(b) + 12'h8, 32'h0, "R1 enable");
         rd(base(b) + 12'h0, 32'h0, "R1 masked");
         rd(base(b) + 12'h4, VMASK, "R1 raw");
      end

      // R2: raw sweep, one hot, both banks share the sources
      for (int i = 0; i < 32; i++) begin
         src = 32'h1 << i;
         for (int b = 0; b < 2; b++) rd(base(b) + 12'h4, raw_m(b), "R2 raw one-hot");
      end

      // R4 / R3 / R9: cumulative set sweep per bank
      src = 32'hA5A5_5A5B;
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 32; i++) begin
            wr(base(b) + 12'h8, 32'h1 << i);
            en_m[b] = en_m[b] | ((32'h1 << i) & VMASK);
            rd(base(b) + 12'h8, en_m[b], "R4 enable set");
            rd(base(b) + 12'h0, raw_m(b) & en_m[b], "R3 masked");
            rd(base(1 - b) + 12'h8, en_m[1 - b], "R9 other bank enable");
         end
      end

      // R5: clear patterns, only written ones cleared
      wr(base(0) + 12'hC, 32'h0F0F_0F0F);
      en_m[0] = en_m[0] & ~32'h0F0F_0F0F;
      rd(base(0) + 12'h8, en_m[0], "R5 clear irq");
      rd(base(1) + 12'h8, en_m[1], "R9 fiq untouched by irq clear");
      wr(base(1) + 12'hC, 32'h8000_0001);
      en_m[1] = en_m[1] & ~32'h8000_0001;
      rd(base(1) + 12'h8, en_m[1], "R5 clear fiq");
      wr(base(1) + 12'hC, 32'h0);
      rd(base(1) + 12'h8, en_m[1], "R5 clear zero");

      // R6: software request
      src = 32'h0;
      wr(base(0) + 12'h10, 32'hFFFF_FFFF);
      soft_m[0] = 1'b1;
      rd(base(0) + 12'h4, 32'h2, "R6 soft on irq raw");
      rd(base(1) + 12'h4, 32'h0, "R6 R9 soft not on fiq");
      wr(base(0) + 12'h10, 32'hFFFF_FFFD);
      soft_m[0] = 1'b0;
      rd(base(0) + 12'h4, 32'h0, "R6 soft cleared by bit1=0");
      wr(base(1) + 12'h10, 32'h0000_0002);
      soft_m[1] = 1'b1;
      rd(base(1) + 12'h4, 32'h2, "R6 soft on fiq raw");
      rd(base(0) + 12'h4, 32'h0, "R6 R9 soft not on irq");
      wr(base(1) + 12'h10, 32'h0);
      soft_m[1] = 1'b0;

      // R7: request timing with partial enables
      wr(base(0) + 12'h8, 32'hFFFF_FFFF); en_m[0] = VMASK;
      wr(base(1) + 12'h8, 32'hFFFF_FFFF); en_m[1] = VMASK;
      wr(base(0) + 12'hC, 32'hFFFF_0000); en_m[0] = en_m[0] & 32'h0000_FFFF;
      @(negedge clk);
      chk({31'b0, irq_req}, 32'h0, "R7 idle irq");
      chk({31'b0, fiq_req}, 32'h0, "R7 idle fiq");
      for (int i = 0; i < 32; i++) begin
         step_src(32'h1 << i);
         step_src(32'h0);
      end

      // R7: request lag after an enable write
      src = 32'h0001_0000;
      @(negedge clk);
      prev_m[0] = req_m(0);
      wr(base(0) + 12'h8, 32'h0001_0000);
      en_m[0] = en_m[0] | 32'h0001_0000;
      chk({31'b0, irq_req}, {31'b0, prev_m[0]}, "R7 lag after enable write");
      @(negedge clk);
      chk({31'b0, irq_req}, {31'b0, req_m(0)}, "R7 follow after enable write");

      // R8: read-only words ignore writes; write-only and unmapped read 0
      wr(base(0) + 12'h0, 32'h0);
      wr(base(0) + 12'h4, 32'hFFFF_FFFF);
      rd(base(0) + 12'h8, en_m[0], "R8 enable after RO writes");
      rd(base(0) + 12'h4, raw_m(0), "R8 raw after RO writes");
      wr(base(1) + 12'h10, 32'h2); soft_m[1] = 1'b1;
      rd(base(1) + 12'h10, 32'h0, "R8 soft reads 0");
      rd(base(1) + 12'hC, 32'h0, "R8 clear reads 0");
      rd(12'h100, 32'h0, "R8 unmapped reads 0");
      rd(base(0) + 12'h9, 32'h0, "R8 unaligned reads 0");
      rd(base(0) + 12'h14, 32'h0, "R8 spare word reads 0");
      rd(base(1) + 12'h4, raw_m(1), "R6 fiq soft raw");
      @(negedge clk);
      chk({31'b0, fiq_req}, {31'b0, req_m(1)}, "R7 fiq soft request");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule